// File: doc/BRIEF.md
# Lockable Cartridge Bank Mapper

This block translates addresses between a 68000-style CPU bus with a 24-bit byte address and a cartridge ROM and battery-backed SRAM. Software programs it through one control byte. It writes that byte by storing to an address inside the lowest 64 KB of cartridge space whose page-select nibble (address bits 11:8) reads 0xE. Bit 7 of the byte maps the top ROM bank into the boot region. The same bit also opens a second SRAM window just below the 4 MB mark. Bit 5 freezes the byte until the next reset, so a game can lock its mapping in place once it has booted.

Both outputs are combinational. The translated ROM address and the chip selects depend only on the presented CPU address and the registered control byte. A control write therefore affects the bus cycle that follows it. The block does not hold the ROM or SRAM arrays, and it does not generate wait states.

Top module: `cart_bank_lock_mapper`

## Requirements
- R1: A write updates the control byte only when address bits 23:16 are 0x00 and address bits 11:8 are 0xE. Any other write leaves the ROM and SRAM decode unchanged.
- R2: The written byte is picked by access size. A word write (`bus_word`=1) uses data bits 7:0. A byte write to an odd address uses data bits 7:0. A byte write to an even address uses data bits 15:8.
- R3: Once bit 5 of the stored control byte is 1, every later control write is ignored until reset.
- R4: With control bit 7 set, an address in 0x000000–0x03FFFF asserts `rom_sel` and gives `rom_addr` = 0x380000 + address[17:0].
- R5: With control bit 7 set, an address in 0x3C0000–0x3FFFFF asserts `sram_sel`, deasserts `rom_sel`, and gives `sram_off` = address[15:0].
- R6: With control bit 7 clear, `rom_addr` equals the CPU address. `rom_sel` is 1 exactly for addresses below 0x400000, and the 0x3C0000 window does not select SRAM.
- R7: An address in 0x400000–0x40FFFF always asserts `sram_sel` with `sram_off` = address[15:0] and deasserts `rom_sel`, whatever the control byte holds. Addresses at or above 0x410000 select nothing.
- R8: Reset (asynchronous, active low) clears the control byte to zero. This leaves the mapper unlocked and unmapped.
- R9: `rom_sel` and `sram_sel` are never both 1. A control write accepted at a clock edge changes the decode for the address presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | CPU byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_word | input | 1 | 1 = 16-bit write, 0 = byte write |
| bus_wdata | input | 16 | CPU write data |
| rom_addr | output | 24 | Translated ROM byte address |
| rom_sel | output | 1 | ROM chip select |
| sram_sel | output | 1 | SRAM chip select |
| sram_off | output | 16 | SRAM byte offset |

## Verification
The bench aims at the edges of the decode windows. It probes 0x03FFFF against 0x040000, 0x3BFFFF against 0x3C0000, 0x3FFFFF against 0x400000, and 0x40FFFF against 0x410000. A design with an off-by-one window would remap or select SRAM one bank too far, or stop one bank short. It writes near misses such as page nibble 0xD and address 0x010E01. A loose decoder would take these as control writes and change the map. It sends even-address byte writes whose two data lanes differ, which exposes a design that reads the wrong lane. It also sets the lock together with the remap bit and then attempts to clear the byte. A design with no lock, or one that tests the wrong bit, would drop the boot-region remap.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    // Address geometry of the cartridge bus
    localparam int ADDR_W      = 24;
    localparam int DATA_W      = 16;
    localparam int CTRL_W      = 8;
    localparam int SRAM_AW     = 16;
    localparam int BANK_SHIFT  = 18;                 // 256 KB banks
    localparam int BANK_W      = ADDR_W - BANK_SHIFT;
    localparam int PAGE_SHIFT  = 16;                 // 64 KB pages
    localparam int PAGE_W      = ADDR_W - PAGE_SHIFT;

    // Control byte bit positions
    localparam int CTRL_LOCK   = 5;
    localparam int CTRL_SWAP   = 7;

    // Decode constants
    localparam logic [3:0]        REG_NIBBLE = 4'hE;
    localparam logic [PAGE_W-1:0] REG_PAGE   = '0;
    localparam logic [BANK_W-1:0] BOOT_BANK  = 6'h00;
    localparam logic [BANK_W-1:0] TOP_BANK   = 6'h0E;   // 0x380000
    localparam logic [BANK_W-1:0] ALIAS_BANK = 6'h0F;   // 0x3C0000
    localparam logic [PAGE_W-1:0] SRAM_PAGE  = 8'h40;   // 0x400000
    localparam logic [1:0]        ROM_TOP    = 2'b00;   // below 0x400000

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } cbm_state_t;
endpackage

// File: rtl/cbm_wr_decode.sv
module cbm_wr_decode
    import cbm_pkg::*;
#(
    parameter int PW = PAGE_W,
    parameter int DW = DATA_W,
    parameter int CW = CTRL_W
) (
    input  logic [PW-1:0] page,
    input  logic [3:0]    nibble,
    input  logic          odd,
    input  logic          we,
    input  logic          word,
    input  logic [DW-1:0] wdata,
    output logic          hit,
    output logic [CW-1:0] wbyte
);
    localparam int HI_LSB = DW - CW;

    always_comb begin
        hit = we && (page == REG_PAGE) && (nibble == REG_NIBBLE);
        if (word || odd) begin
            wbyte = wdata[CW-1:0];
        end else begin
            wbyte = wdata[DW-1:HI_LSB];
        end
    end
endmodule

// File: rtl/cbm_ctrl_reg.sv
module cbm_ctrl_reg
    import cbm_pkg::*;
#(
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [CW-1:0] wbyte,
    output logic [CW-1:0] ctrl
);
    cbm_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (hit && !state_q.ctrl[CTRL_LOCK]) begin
            state_d.ctrl = wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl = state_q.ctrl;
endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate
    import cbm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CTRL_W,
    parameter int SW = SRAM_AW
) (
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] ctrl,
    output logic [AW-1:0] rom_addr,
    output logic          rom_sel,
    output logic          sram_sel,
    output logic [SW-1:0] sram_off
);
    localparam int BW = AW - BANK_SHIFT;
    localparam int PW = AW - PAGE_SHIFT;

    logic [BW-1:0] bank;
    logic [PW-1:0] page;
    logic          swap;
    logic          in_rom;
    logic          in_alias;
    logic          in_base;

    always_comb begin
        bank     = addr[AW-1:BANK_SHIFT];
        page     = addr[AW-1:PAGE_SHIFT];
        swap     = ctrl[CTRL_SWAP];
        in_rom   = (addr[AW-1:AW-2] == ROM_TOP);
        in_alias = swap && (bank == ALIAS_BANK);
        in_base  = (page == SRAM_PAGE);

        rom_addr = addr;
        if (swap && bank == BOOT_BANK) begin
            rom_addr = {TOP_BANK, addr[BANK_SHIFT-1:0]};
        end
        sram_sel = in_alias || in_base;
        rom_sel  = in_rom && !in_alias;
        sram_off = addr[SW-1:0];
    end
endmodule

// File: rtl/cart_bank_lock_mapper.sv
module cart_bank_lock_mapper
    import cbm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic               bus_word,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [ADDR_W-1:0]  rom_addr,
    output logic               rom_sel,
    output logic               sram_sel,
    output logic [SRAM_AW-1:0] sram_off
);
    logic              wr_hit;
    logic [CTRL_W-1:0] wr_byte;
    logic [CTRL_W-1:0] ctrl_q;

    cbm_wr_decode u_dec (
        .page   (bus_addr[ADDR_W-1:PAGE_SHIFT]),
        .nibble (bus_addr[11:8]),
        .odd    (bus_addr[0]),
        .we     (bus_we),
        .word   (bus_word),
        .wdata  (bus_wdata),
        .hit    (wr_hit),
        .wbyte  (wr_byte)
    );

    cbm_ctrl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (wr_hit),
        .wbyte (wr_byte),
        .ctrl  (ctrl_q)
    );

    cbm_xlate u_xlate (
        .addr     (bus_addr),
        .ctrl     (ctrl_q),
        .rom_addr (rom_addr),
        .rom_sel  (rom_sel),
        .sram_sel (sram_sel),
        .sram_off (sram_off)
    );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker
    import cbm_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [CTRL_W-1:0]  ctrl_q,
    input logic [ADDR_W-1:0]  rom_addr,
    input logic               rom_sel,
    input logic               sram_sel,
    input logic [SRAM_AW-1:0] sram_off
);
    AST_WR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[23:16] != 8'h00) |=> $stable(ctrl_q)); // R1
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[5] |=> $stable(ctrl_q)); // R3
    AST_BOOT_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7] && bus_addr[23:18] == 6'h00) |-> (rom_sel && rom_addr[23:18] == 6'h0E)); // R4
    AST_ALIAS_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7] && bus_addr[23:18] == 6'h0F) |-> (sram_sel && !rom_sel && sram_off == bus_addr[15:0])); // R5
    AST_ALIAS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[7] && bus_addr[23:18] == 6'h0F) |-> (!sram_sel && rom_sel)); // R6
    AST_BASE_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[23:16] == 8'h40) |-> (sram_sel && !rom_sel)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_q == 8'h00)); // R8
    AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rom_sel, sram_sel}) <= 1); // R9
endmodule

bind cart_bank_lock_mapper cbm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .ctrl_q   (ctrl_q),
    .rom_addr (rom_addr),
    .rom_sel  (rom_sel),
    .sram_sel (sram_sel),
    .sram_off (sram_off)
);

// File: tb/cart_bank_lock_mapper_bench.sv
module cart_bank_lock_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_word = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [23:0] rom_addr;
    logic        rom_sel;
    logic        sram_sel;
    logic [15:0] sram_off;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;   // 50 MHz

    cart_bank_lock_mapper u_cart_bank_lock_mapper (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .rom_addr(rom_addr),
        .rom_sel(rom_sel), .sram_sel(sram_sel), .sram_off(sram_off)
    );

    // Reference model: new control byte after a write (R1, R2, R3)
    function automatic logic [7:0] next_ctrl(logic [7:0] cur, logic [23:0] a,
                                             logic word, logic [15:0] d);
        if (cur[5]) return cur;
        if (a > 24'h00FFFF) return cur;
        if (((a >> 8) & 24'hF) != 24'hE) return cur;
        if (word || a[0]) return d[7:0];
        return d[15:8];
    endfunction

    function automatic logic [23:0] exp_rom_addr(logic [7:0] c, logic [23:0] a);
        if (c[7] && a < 24'h040000) return 24'h380000 + (a & 24'h03FFFF);
        return a;
    endfunction

    function automatic logic exp_rom_sel(logic [7:0] c, logic [23:0] a);
        if (a >= 24'h400000) return 1'b0;
        if (c[7] && a >= 24'h3C0000) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic exp_sram_sel(logic [7:0] c, logic [23:0] a);
        if (a >= 24'h400000 && a <= 24'h40FFFF) return 1'b1;
        if (c[7] && a >= 24'h3C0000 && a <= 24'h3FFFFF) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%06h ctrl_model=%02h actual=%0h expected=%0h",
                     req, bus_addr, model, act, exp);
        end
    endtask

    task automatic probe(logic [23:0] a, string req);
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        #2;
        check({req, " rom_addr"}, 32'(rom_addr), 32'(exp_rom_addr(model, a)));
        check({req, " rom_sel"},  32'(rom_sel),  32'(exp_rom_sel(model, a)));
        check({req, " sram_sel"}, 32'(sram_sel), 32'(exp_sram_sel(model, a)));
        if (exp_sram_sel(model, a))
            check({req, " sram_off"}, 32'(sram_off), 32'(a[15:0]));
    endtask

    task automatic wr(logic [23:0] a, logic word, logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_word  = word;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        model = next_ctrl(model, a, word, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        // R8: reset state seen on outputs while reset is held
        #5;
        probe(24'h000100, "R8 in reset");
        probe(24'h3C0010, "R8 R6 in reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        probe(24'h03FFFF, "R6 passthrough");
        probe(24'h3C0000, "R6 alias closed");
        probe(24'h40FFFF, "R7 base top");
        probe(24'h410000, "R7 above base");

        // R1 near misses
        wr(24'h000D01, 1'b0, 16'h0080);
        probe(24'h000000, "R1 nibble D");
        wr(24'h010E01, 1'b0, 16'h0080);
        probe(24'h000000, "R1 page 1");

        // R2 lanes, R9 next-cycle effect
        wr(24'h000E00, 1'b0, 16'h8000);
        probe(24'h000000, "R2 R9 even lane");
        probe(24'h03FFFF, "R4 window top");
        probe(24'h040000, "R4 past window");
        probe(24'h3BFFFF, "R5 below alias");
        probe(24'h3C0000, "R5 alias low");
        probe(24'h3FFFFF, "R5 alias high");
        probe(24'h400000, "R7 base low");
        wr(24'h000E00, 1'b1, 16'h8000);
        probe(24'h000123, "R2 word low lane");
        wr(24'h00FE01, 1'b0, 16'h0080);
        probe(24'h000123, "R2 odd low lane");

        // R3 lock with remap, then attempt to clear
        wr(24'h000E01, 1'b0, 16'h00A0);
        wr(24'h000E01, 1'b0, 16'h0000);
        probe(24'h001000, "R3 locked keeps remap");
        probe(24'h3C4567, "R3 locked alias");
        do_reset();
        probe(24'h001000, "R8 unlocked after reset");
        wr(24'h000E01, 1'b1, 16'h0020);
        wr(24'h000E01, 1'b1, 16'h0080);
        probe(24'h001000, "R3 lock without remap");
        do_reset();

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 99);
            logic [23:0] a;
            if (sel < 30) begin
                a = {8'h00, 4'($urandom), 4'hE, 8'($urandom)};
                wr(a, 1'($urandom), 16'($urandom));
            end else if (sel < 40) begin
                wr(24'($urandom), 1'($urandom), 16'($urandom));
            end else if (sel < 42) begin
                do_reset();
            end else begin
                case ($urandom_range(0, 4))
                    0: a = {6'h00, 18'($urandom)};
                    1: a = {6'h0F, 18'($urandom)};
                    2: a = {8'h40, 16'($urandom)};
                    3: a = {6'($urandom_range(1, 14)), 18'($urandom)};
                    default: a = 24'($urandom);
                endcase
                probe(a, "R4 R5 R6 R7 R9 random");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule